// File: doc/BRIEF.md
# Interposer Reconfiguration Sequencer

This block is the system-level manager of a photonic interposer that links several chiplets. At the end of each reconfiguration interval every chiplet reports how many of its optical gateways it wants active. The sequencer latches those reports, derives the set of gateways that should be on and the system-wide total, and then applies the change in an order that never leaves an enabled gateway short of optical power.

When gateways are to be added, the laser drive code is raised and the per-writer couplers are reprogrammed first. The new gateways are enabled only after a fixed coupler settling window has elapsed. When gateways are to be removed, the sequencer waits until every gateway being removed reports an empty queue, then disables them, and only then lowers the laser code and clears their couplers. A report that changes no chiplet's count completes without touching any output. The laser hardware, the couplers and the load estimation that produces the counts are outside this block.

Top module: `ixr_seq`

## Requirements
- R1: After reset all N_CHIP*GW_PER_CHIP gateways and couplers are enabled, every coupler share code equals N_CHIP*GW_PER_CHIP, the laser code equals LASER_STEP times that number, total_active equals it, and busy and done are low.
- R2: A report is taken when rpt_valid is high while busy is low. Chiplet c's count sits in rpt_counts bits [c*CW +: CW] with CW = clog2(GW_PER_CHIP+1); a count above GW_PER_CHIP is treated as GW_PER_CHIP. A count k enables gateways c*GW_PER_CHIP to c*GW_PER_CHIP+k-1, and when done pulses total_active holds the sum of the clamped counts.
- R3: A report presented while busy is high is ignored and does not change the outcome of the sequence in progress.
- R4: When any gateway is to be added, the laser code rises to LASER_STEP times the number of gateways in the union of the current and requested sets before any new gateway is enabled, and the new gateways are enabled exactly SETTLE_CYC+1 cycles after that rise.
- R5: A gateway being removed is never disabled while its gw_empty bit is low; removal happens once all gateways being removed report empty.
- R6: The laser code is lowered to LASER_STEP times the new total exactly one cycle after the gateways are disabled, and at every cycle it is at least LASER_STEP times the number of enabled gateways.
- R7: A writer whose coupler is disabled has share code zero; when done pulses, every enabled coupler matches an enabled gateway and holds the new total as its share code.
- R8: Every enabled gateway always has its coupler enabled.
- R9: A report that leaves every chiplet's count unchanged raises done on the third clock edge after the report is taken, with no change to gateways, couplers or laser code; done is a single-cycle pulse after which busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rpt_valid | input | 1 | Per-chiplet requested counts are valid |
| rpt_counts | input | N_CHIP*CW | Requested active-gateway count per chiplet |
| gw_empty | input | N_CHIP*GW_PER_CHIP | Per-gateway queue empty flag |
| gw_en | output | N_CHIP*GW_PER_CHIP | Gateway enable |
| cpl_en | output | N_CHIP*GW_PER_CHIP | Per-writer coupler enable |
| cpl_share | output | N_CHIP*GW_PER_CHIP*TW | Per-writer coupler share code (number of writers sharing the laser) |
| laser_code | output | LW | Laser drive code |
| total_active | output | TW | Committed system total of active gateways |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse when a sequence completes |

## Verification
The hardest situation to reach is a removal that stalls with some of the outgoing gateways still holding traffic while a mixed report both adds and removes gateways. The bench holds every empty flag low for a chosen number of cycles after the report, sweeping that hold across many count patterns, and watches that no outgoing gateway falls early and that the laser drops exactly one cycle after the gateways. Reports injected mid-sequence and over-range counts are driven to reach the ignore and clamp corners.

// File: rtl/ixr_pkg.sv
package ixr_pkg;
  typedef enum logic [3:0] {
    S_IDLE,
    S_COLLECT,
    S_RAISE,
    S_SETTLE,
    S_ENABLE,
    S_FLUSH,
    S_DISABLE,
    S_LOWER,
    S_DONE
  } seq_state_t;
endpackage

// File: rtl/ixr_demand.sv
module ixr_demand #(
  parameter int N_CHIP      = 4,
  parameter int GW_PER_CHIP = 4,
  localparam int NG = N_CHIP * GW_PER_CHIP,
  localparam int CW = $clog2(GW_PER_CHIP + 1),
  localparam int TW = $clog2(NG + 1)
) (
  input  logic [N_CHIP*CW-1:0] counts,
  output logic [NG-1:0]        mask,
  output logic [TW-1:0]        total
);
  logic [CW-1:0] clamp_w [N_CHIP];

  for (genvar c = 0; c < N_CHIP; c++) begin : g_chip
    always_comb begin
      if (counts[c*CW +: CW] > CW'(GW_PER_CHIP)) clamp_w[c] = CW'(GW_PER_CHIP);
      else                                       clamp_w[c] = counts[c*CW +: CW];
    end
    for (genvar j = 0; j < GW_PER_CHIP; j++) begin : g_gw
      assign mask[c*GW_PER_CHIP + j] = (CW'(j) < clamp_w[c]);
    end
  end

  always_comb begin
    total = '0;
    for (int c = 0; c < N_CHIP; c++) total = total + TW'(clamp_w[c]);
  end
endmodule

// File: rtl/ixr_timer.sv
module ixr_timer #(
  parameter int LIMIT = 100,
  localparam int CNTW = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic expired
);
  logic            run_q;
  logic [CNTW-1:0] cnt_q;

  assign expired = run_q && (cnt_q == CNTW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (start) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else if (run_q) begin
      if (expired) run_q <= 1'b0;
      else         cnt_q <= cnt_q + 1'b1;
    end
  end

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (cnt_q < CNTW'(LIMIT)));
endmodule

// File: rtl/ixr_coupler.sv
module ixr_coupler #(
  parameter int NG = 16,
  localparam int TW = $clog2(NG + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [NG-1:0]   mask,
  input  logic [TW-1:0]   share,
  output logic [NG-1:0]   en,
  output logic [NG*TW-1:0] ratio
);
  for (genvar i = 0; i < NG; i++) begin : g_wr
    logic          en_q;
    logic [TW-1:0] sh_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        en_q <= 1'b1;
        sh_q <= TW'(NG);
      end else if (load) begin
        en_q <= mask[i];
        sh_q <= mask[i] ? share : '0;
      end
    end

    assign en[i]            = en_q;
    assign ratio[i*TW +: TW] = sh_q;

    // R7
    off_zero_chk: assert property (@(posedge clk) disable iff (rst)
      !en_q |-> (sh_q == '0));
  end
endmodule

// File: rtl/ixr_seq.sv
module ixr_seq
  import ixr_pkg::*;
#(
  parameter int N_CHIP      = 4,
  parameter int GW_PER_CHIP = 4,
  parameter int SETTLE_CYC  = 100,
  parameter int LASER_STEP  = 3,
  localparam int NG = N_CHIP * GW_PER_CHIP,
  localparam int CW = $clog2(GW_PER_CHIP + 1),
  localparam int TW = $clog2(NG + 1),
  localparam int LW = $clog2(NG * LASER_STEP + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rpt_valid,
  input  logic [N_CHIP*CW-1:0] rpt_counts,
  input  logic [NG-1:0]        gw_empty,
  output logic [NG-1:0]        gw_en,
  output logic [NG-1:0]        cpl_en,
  output logic [NG*TW-1:0]     cpl_share,
  output logic [LW-1:0]        laser_code,
  output logic [TW-1:0]        total_active,
  output logic                 busy,
  output logic                 done
);
  function automatic int popc(input logic [NG-1:0] v);
    int n = 0;
    for (int i = 0; i < NG; i++) n += int'(v[i]);
    return n;
  endfunction

  seq_state_t          state_q;
  logic [N_CHIP*CW-1:0] req_q;
  logic [NG-1:0]       nm_q, add_q, drop_q, gw_q;
  logic [TW-1:0]       nt_q, tot_q;
  logic [LW-1:0]       laser_q;
  logic                done_q;

  logic [NG-1:0]       dm_mask;
  logic [TW-1:0]       dm_total;
  logic                settle_done;
  logic                cpl_load;
  logic [NG-1:0]       cpl_mask;
  logic [TW-1:0]       cpl_sh_in;
  logic [NG-1:0]       union_w;

  ixr_demand #(.N_CHIP(N_CHIP), .GW_PER_CHIP(GW_PER_CHIP)) u_dem (
    .counts (req_q),
    .mask   (dm_mask),
    .total  (dm_total)
  );

  ixr_timer #(.LIMIT(SETTLE_CYC)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .start   (state_q == S_RAISE),
    .expired (settle_done)
  );

  assign union_w   = gw_q | nm_q;
  assign cpl_load  = (state_q == S_RAISE) || (state_q == S_LOWER);
  assign cpl_mask  = (state_q == S_RAISE) ? union_w : nm_q;
  assign cpl_sh_in = (state_q == S_RAISE) ? TW'(popc(union_w)) : nt_q;

  ixr_coupler #(.NG(NG)) u_cpl (
    .clk   (clk),
    .rst   (rst),
    .load  (cpl_load),
    .mask  (cpl_mask),
    .share (cpl_sh_in),
    .en    (cpl_en),
    .ratio (cpl_share)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      req_q   <= '0;
      nm_q    <= '0;
      nt_q    <= '0;
      add_q   <= '0;
      drop_q  <= '0;
      gw_q    <= '1;
      laser_q <= LW'(NG * LASER_STEP);
      tot_q   <= TW'(NG);
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (rpt_valid) begin
            req_q   <= rpt_counts;
            state_q <= S_COLLECT;
          end
        end
        S_COLLECT: begin
          nm_q   <= dm_mask;
          nt_q   <= dm_total;
          add_q  <= dm_mask & ~gw_q;
          drop_q <= gw_q & ~dm_mask;
          if (|(dm_mask & ~gw_q))      state_q <= S_RAISE;
          else if (|(gw_q & ~dm_mask)) state_q <= S_FLUSH;
          else                         state_q <= S_DONE;
        end
        S_RAISE: begin
          laser_q <= LW'(popc(union_w) * LASER_STEP);
          state_q <= S_SETTLE;
        end
        S_SETTLE: begin
          if (settle_done) state_q <= S_ENABLE;
        end
        S_ENABLE: begin
          gw_q    <= gw_q | add_q;
          state_q <= (|drop_q) ? S_FLUSH : S_DONE;
        end
        S_FLUSH: begin
          if ((gw_empty & drop_q) == drop_q) state_q <= S_DISABLE;
        end
        S_DISABLE: begin
          gw_q    <= gw_q & ~drop_q;
          state_q <= S_LOWER;
        end
        S_LOWER: begin
          laser_q <= LW'(int'(nt_q) * LASER_STEP);
          state_q <= S_DONE;
        end
        S_DONE: begin
          tot_q   <= nt_q;
          done_q  <= 1'b1;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign gw_en        = gw_q;
  assign laser_code   = laser_q;
  assign total_active = tot_q;
  assign busy         = (state_q != S_IDLE);
  assign done         = done_q;

  // R3
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && rpt_valid) |=> $stable(req_q));

  // R4
  enable_after_settle_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_ENABLE) |-> ($past(state_q) == S_SETTLE && $past(settle_done)));

  // R5
  flush_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((state_q == S_FLUSH) && ((gw_empty & drop_q) != drop_q)) |=> $stable(gw_q));

  // R6
  laser_move_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(laser_q) |-> ($past(state_q) == S_RAISE || $past(state_q) == S_LOWER));

  // R6
  laser_cover_chk: assert property (@(posedge clk) disable iff (rst)
    int'(laser_q) >= popc(gw_q) * LASER_STEP);

  // R8
  gw_cpl_chk: assert property (@(posedge clk) disable iff (rst)
    (gw_q & ~cpl_en) == '0);
endmodule

// File: tb/sim_ixr_seq.sv
`timescale 1ns/1ps
module sim_ixr_seq;
  localparam int N    = 4;
  localparam int G    = 4;
  localparam int NG   = N * G;
  localparam int CW   = 3;
  localparam int TW   = 5;
  localparam int LW   = 6;
  localparam int STEP = 3;
  localparam int SET  = 100;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              rpt_valid = 1'b0;
  logic [N*CW-1:0]   rpt_counts = '0;
  logic [NG-1:0]     gw_empty = '1;
  logic [NG-1:0]     gw_en, cpl_en;
  logic [NG*TW-1:0]  cpl_share;
  logic [LW-1:0]     laser_code;
  logic [TW-1:0]     total_active;
  logic              busy, done;

  int n_cmp = 0;
  int n_bad = 0;
  bit fin = 1'b0;
  logic [NG-1:0] model = '1;

  always #2.5 clk = ~clk;

  ixr_seq #(.N_CHIP(N), .GW_PER_CHIP(G), .SETTLE_CYC(SET), .LASER_STEP(STEP)) u0 (
    .clk(clk), .rst(rst), .rpt_valid(rpt_valid), .rpt_counts(rpt_counts),
    .gw_empty(gw_empty), .gw_en(gw_en), .cpl_en(cpl_en), .cpl_share(cpl_share),
    .laser_code(laser_code), .total_active(total_active), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int pc(input logic [NG-1:0] v);
    int n = 0;
    for (int i = 0; i < NG; i++) n += int'(v[i]);
    return n;
  endfunction

  function automatic logic [N*CW-1:0] mk(input int a, input int b, input int c, input int d);
    logic [N*CW-1:0] r;
    r[0*CW +: CW] = CW'(a);
    r[1*CW +: CW] = CW'(b);
    r[2*CW +: CW] = CW'(c);
    r[3*CW +: CW] = CW'(d);
    return r;
  endfunction

  function automatic logic [NG-1:0] exp_mask(input logic [N*CW-1:0] cnt);
    logic [NG-1:0] m = '0;
    for (int c = 0; c < N; c++) begin
      int k = int'(cnt[c*CW +: CW]);
      if (k > G) k = G;
      for (int j = 0; j < k; j++) m[c*G + j] = 1'b1;
    end
    return m;
  endfunction

  // continuous port-level watch
  logic [NG-1:0] prev_gw = '1;
  logic [NG-1:0] prev_empty = '1;
  always @(negedge clk) begin
    if (!rst) begin
      if ((gw_en & ~cpl_en) != '0)
        chk(1'b0, "R8 gateway without coupler", longint'(gw_en), longint'(cpl_en));
      if (int'(laser_code) < pc(gw_en) * STEP)
        chk(1'b0, "R6 laser below enabled load", laser_code, pc(gw_en) * STEP);
      if ((prev_gw & ~gw_en & ~prev_empty) != '0)
        chk(1'b0, "R5 non-empty gateway disabled", longint'(gw_en), longint'(prev_gw));
      for (int i = 0; i < NG; i++)
        if (!cpl_en[i] && cpl_share[i*TW +: TW] != '0)
          chk(1'b0, "R7 disabled coupler share", cpl_share[i*TW +: TW], 0);
    end
    prev_gw    = gw_en;
    prev_empty = gw_empty;
  end

  task automatic apply(input logic [N*CW-1:0] cnt, input int hold, input bit junk);
    logic [NG-1:0] em;
    int et, w, t_lu, t_ld, t_gu, t_gd;
    bit grow, shrink;
    logic [LW-1:0] lp;
    logic [NG-1:0] gp;
    em = exp_mask(cnt);
    et = pc(em);
    grow   = |(em & ~model);
    shrink = |(model & ~em);
    t_lu = -1; t_ld = -1; t_gu = -1; t_gd = -1;
    @(negedge clk);
    rpt_counts = cnt;
    rpt_valid  = 1'b1;
    gw_empty   = (hold > 0) ? '0 : '1;
    lp = laser_code;
    gp = gw_en;
    @(negedge clk);
    rpt_valid = 1'b0;
    w = 1;
    while (!done && w < 1000) begin
      @(negedge clk);
      w++;
      if (w == hold + 1) gw_empty = '1;
      if (junk && w == 10) begin rpt_valid = 1'b1; rpt_counts = '0; end
      if (junk && w == 11) rpt_valid = 1'b0;
      if (laser_code > lp && t_lu < 0) t_lu = w;
      if (laser_code < lp) t_ld = w;
      if ((gw_en & ~gp) != '0) t_gu = w;
      if ((gp & ~gw_en) != '0) t_gd = w;
      lp = laser_code;
      gp = gw_en;
    end
    chk(done, "R9 sequence completes", w, 0);
    chk(gw_en == em, junk ? "R3 R2 gateway set after ignored report" : "R2 gateway set",
        longint'(gw_en), longint'(em));
    chk(int'(total_active) == et, "R2 total", total_active, et);
    chk(cpl_en == em, "R7 coupler enables", longint'(cpl_en), longint'(em));
    for (int i = 0; i < NG; i++)
      if (em[i] && int'(cpl_share[i*TW +: TW]) != et)
        chk(1'b0, "R7 active share", cpl_share[i*TW +: TW], et);
    chk(int'(laser_code) == et * STEP, "R6 final laser code", laser_code, et * STEP);
    if (grow) begin
      chk(t_lu > 0 && t_gu > 0, "R4 laser rise and enable seen", t_lu, t_gu);
      chk(t_gu - t_lu == SET + 1, "R4 settle gap", t_gu - t_lu, SET + 1);
    end
    if (shrink) begin
      chk(t_ld - t_gd == 1, "R6 laser lowered after disable", t_ld - t_gd, 1);
      if (hold > 0) chk(t_gd >= hold + 2, "R5 waited for empty", t_gd, hold + 2);
    end
    if (!grow && !shrink) begin
      chk(w == 3, "R9 unchanged latency", w, 3);
      chk(t_lu < 0 && t_ld < 0 && t_gu < 0 && t_gd < 0, "R9 nothing touched", t_gu, -1);
    end
    @(negedge clk);
    chk(!done && !busy, "R9 single done pulse then idle", {done, busy}, 0);
    model = em;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(gw_en == '1, "R1 gateways on", longint'(gw_en), longint'({NG{1'b1}}));
    chk(cpl_en == '1, "R1 couplers on", longint'(cpl_en), longint'({NG{1'b1}}));
    chk(int'(cpl_share[0 +: TW]) == NG && int'(cpl_share[(NG-1)*TW +: TW]) == NG,
        "R1 share codes", cpl_share[0 +: TW], NG);
    chk(int'(laser_code) == NG * STEP, "R1 laser code", laser_code, NG * STEP);
    chk(int'(total_active) == NG && !busy && !done, "R1 total and flags", total_active, NG);

    apply(mk(4, 4, 4, 4), 0, 1'b0);   // unchanged
    apply(mk(1, 2, 3, 0), 7, 1'b0);   // shrink with stalled flush
    apply(mk(4, 4, 2, 1), 0, 1'b1);   // grow with mid-sequence report
    apply(mk(7, 5, 6, 0), 0, 1'b0);   // over-range counts clamp
    apply(mk(0, 0, 0, 0), 3, 1'b0);   // everything off
    apply(mk(0, 0, 0, 0), 0, 1'b0);   // unchanged at zero
    for (int i = 0; i < 24; i++)
      apply(mk((i * 3) % 6, (i * 5 + 1) % 6, (i * 2 + 3) % 6, (i * 7 + 2) % 6), (i % 3) * 4, 1'b0);
    apply(model == '1 ? mk(3, 3, 3, 3) : mk(4, 4, 4, 4), 5, 1'b0);

    fin = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!fin) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired for all requirements act=1 exp=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule